// File: doc/BRIEF.md
# Unaligned Transfer Splitter

This block turns a read request, given as a start address and a byte count, into a series of bus operations. It puts out one operation at a time. Bytes that come before the first 8-byte boundary are read one at a time. The aligned middle of the range is read in 8-byte blocks. Any bytes left over at the end are read one at a time as well. Each operation carries an address, a size code and a path select bit. The path select sends 8-byte blocks to a DMA engine and single bytes to the processor path.

A requester offers a request while `req_ready` is high. The splitter then presents operations on a valid/ready handshake until the whole count has been covered. It raises `done` for one cycle after the last operation is accepted, and it takes no new request until that has happened. Moving the data and handling errors reported downstream are left to the consumers of the operations.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `op_valid` is 0 and `done` is 0.
- R2: While the current address is not a multiple of 8, each operation is a 1-byte read: `op_size` = 0 (size code = log2 of the byte count), `op_dma` = 0, and each address is one more than the previous one.
- R3: Once the address is a multiple of 8 and at least 8 bytes remain, each operation is an 8-byte read: `op_size` = 3, `op_dma` = 1, and each address is 8 more than the previous one.
- R4: When fewer than 8 bytes remain at an aligned address, each remaining byte is read with its own 1-byte operation (`op_size` = 0, `op_dma` = 0).
- R5: A request with a count of zero issues no operation. `done` is high in the cycle after the request is accepted.
- R6: If the count runs out before the address reaches a multiple of 8, the block issues only 1-byte operations and then signals done.
- R7: While `op_valid` is high and `op_ready` is low, `op_valid`, `op_addr`, `op_size` and `op_dma` stay unchanged. The address and the remaining count advance only when an operation is accepted.
- R8: `req_ready` is high only while the block is idle. A `req_valid` raised while the block is busy has no effect on the operations being issued.
- R9: `done` is a one-cycle pulse in the cycle after the last operation is accepted. `op_valid` is low while `done` is high. `req_ready` returns to 1 in the cycle after that.
- R10: The sizes of all operations issued for a request add up to exactly the requested count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count |
| op_valid | output | 1 | Operation presented |
| op_ready | input | 1 | Operation taken by the downstream path |
| op_addr | output | AW | Operation byte address |
| op_size | output | 2 | log2 of the operation size in bytes (0 or 3) |
| op_dma | output | 1 | 1 = DMA path, 0 = processor path |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The hardest case to reach is a request that arrives while the block is busy and a downstream stall that lands exactly at the change from head to body or from body to tail. At those points the register that holds the current operation must keep its old value while the size and path for the next operation are already different. The bench offers misaligned starts with counts that cover all three phases. On a fixed pattern it holds `op_ready` low, so some stalls fall on the phase changes. It also raises `req_valid` with a different address while operations are still being issued. Every accepted operation is compared with a list built in the bench from the start address and the count alone.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // Operation size code: log2 of the byte count
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_BLOCK = 2'd3
  } op_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } split_state_e;
endpackage

// File: rtl/xfer_op_plan.sv
// Picks the kind of the next operation from the current address and the remaining count.
module xfer_op_plan #(
  parameter int AW       = 32,
  parameter int LW       = 24,
  parameter int BLK_LOG2 = 3
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [LW-1:0] cur_rem,
  output logic          is_blk,
  output logic [LW-1:0] step
);
  localparam int BLK_BYTES = 1 << BLK_LOG2;
  localparam logic [LW-1:0] BLK_LEN = LW'(BLK_BYTES);

  logic aligned;

  generate
    if (BLK_LOG2 == 0) begin : g_no_align
      assign aligned = 1'b1;
    end else begin : g_align
      assign aligned = (cur_addr[BLK_LOG2-1:0] == '0);
    end
  endgenerate

  always_comb begin
    is_blk = aligned && (cur_rem >= BLK_LEN);
    step   = is_blk ? BLK_LEN : LW'(1);
  end
endmodule

// File: rtl/xfer_cursor.sv
// Holds the current address and the remaining byte count.
module xfer_cursor #(
  parameter int AW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          adv,
  input  logic [LW-1:0] step,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] cur_rem,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_rem  <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      cur_rem  <= ld_len;
    end else if (adv) begin
      cur_addr <= cur_addr + AW'(step);
      cur_rem  <= cur_rem - step;
    end
  end

  assign last = (cur_rem == step);
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter #(
  parameter int AW       = 32,
  parameter int LW       = 24,
  parameter int BLK_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [AW-1:0] op_addr,
  output logic [1:0]    op_size,
  output logic          op_dma,
  output logic          done
);
  import xfer_pkg::*;

  localparam logic [1:0] BLK_CODE = 2'(BLK_LOG2);

  split_state_e state;
  logic          load, adv, last, is_blk;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] cur_rem, step;

  assign load = (state == ST_IDLE) && req_valid;
  assign adv  = (state == ST_ISSUE) && op_ready;

  xfer_cursor #(.AW(AW), .LW(LW)) u_cursor (
    .clk(clk), .rst(rst), .load(load), .ld_addr(req_addr), .ld_len(req_len),
    .adv(adv), .step(step), .cur_addr(cur_addr), .cur_rem(cur_rem), .last(last)
  );

  xfer_op_plan #(.AW(AW), .LW(LW), .BLK_LOG2(BLK_LOG2)) u_plan (
    .cur_addr(cur_addr), .cur_rem(cur_rem), .is_blk(is_blk), .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (req_valid) state <= (req_len == '0) ? ST_DONE : ST_ISSUE;
        ST_ISSUE: if (op_ready && last) state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign op_valid  = (state == ST_ISSUE);
  assign done      = (state == ST_DONE);
  assign op_addr   = cur_addr;
  assign op_size   = is_blk ? BLK_CODE : SZ_BYTE;
  assign op_dma    = is_blk;
endmodule

// File: rtl/xfer_splitter_chk.sv
module xfer_splitter_chk #(
  parameter int AW       = 32,
  parameter int LW       = 24,
  parameter int BLK_LOG2 = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          op_valid,
  input logic          op_ready,
  input logic [AW-1:0] op_addr,
  input logic [1:0]    op_size,
  input logic          op_dma,
  input logic          done
);
  // R3: a DMA operation is always a full aligned block
  a_r3_dma_aligned: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_dma) |-> (op_size == 2'(BLK_LOG2) && op_addr[BLK_LOG2-1:0] == '0));

  // R2, R4: a byte operation is never sent on the DMA path
  a_r2_byte_cpu: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_size == 2'd0) |-> !op_dma);

  // R7: a stalled operation holds all its fields
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_addr) && $stable(op_size) && $stable(op_dma)));

  // R8: the block is never ready while it issues an operation
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!op_valid && !done));

  // R9: done lasts one cycle, never together with an operation, and follows it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));
  a_r9_done_no_op: assert property (@(posedge clk) disable iff (rst)
    done |-> !op_valid);
  a_r9_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(op_valid) |-> done);
endmodule

bind xfer_splitter xfer_splitter_chk #(.AW(AW), .LW(LW), .BLK_LOG2(BLK_LOG2)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .op_valid(op_valid), .op_ready(op_ready),
  .op_addr(op_addr), .op_size(op_size), .op_dma(op_dma), .done(done)
);

// File: tb/xfer_splitter_tb.sv
module xfer_splitter_tb;
  localparam int AW = 32;
  localparam int LW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          op_valid;
  logic          op_ready = 1'b0;
  logic [AW-1:0] op_addr;
  logic [1:0]    op_size;
  logic          op_dma;
  logic          done;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  xfer_splitter #(.AW(AW), .LW(LW), .BLK_LOG2(3)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .op_valid(op_valid), .op_ready(op_ready),
    .op_addr(op_addr), .op_size(op_size), .op_dma(op_dma), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Runs one request and compares every operation with a list computed here.
  task automatic run_xfer(input logic [AW-1:0] a, input logic [LW-1:0] n,
                          input bit stall, input bit poke, input string req,
                          input bit expect_no_blk);
    logic [AW-1:0] ea = a;
    int rem = int'(n);
    int total = 0;
    int k = 0;
    int blks = 0;
    bit blk;
    @(negedge clk);
    check(req_ready == 1'b1, req, "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_len = n;
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(done == 1'b1 && op_valid == 1'b0, "R5", "zero count done", {done, op_valid}, 2);
    end
    while (rem > 0) begin
      blk = (ea[2:0] == 3'd0) && (rem >= 8);
      check(op_valid == 1'b1, req, "op_valid", op_valid, 1);
      check(op_addr == ea, blk ? "R3" : (ea[2:0] != 0 ? "R2" : "R4"), "op_addr", op_addr, ea);
      check(op_size == (blk ? 2'd3 : 2'd0), blk ? "R3" : "R4", "op_size", op_size, blk ? 3 : 0);
      check(op_dma == blk, blk ? "R3" : "R2", "op_dma", op_dma, blk);
      if (stall && (k % 3 == 0)) begin
        op_ready = 1'b0;
        @(negedge clk);
        check(op_valid && op_addr == ea && op_size == (blk ? 2'd3 : 2'd0) && op_dma == blk,
              "R7", "held during stall", op_addr, ea);
      end
      if (poke && k == 0) begin
        req_valid = 1'b1; req_addr = 32'h0000_0F00; req_len = 24'd64;
        check(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
      end
      op_ready = 1'b1;
      @(negedge clk);
      op_ready = 1'b0;
      if (poke && k == 0) req_valid = 1'b0;
      total += blk ? 8 : 1;
      if (blk) blks++;
      ea  = ea + (blk ? 32'd8 : 32'd1);
      rem = rem - (blk ? 8 : 1);
      k++;
      if (k > 100000) break;
    end
    check(total == int'(n), "R10", "summed sizes", total, n);
    if (expect_no_blk) check(blks == 0, "R6", "no block reads", blks, 0);
    check(done == 1'b1 && op_valid == 1'b0, "R9", "done after last op", {done, op_valid}, 2);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, "R9", "done single cycle", {done, req_ready}, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1 && op_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
          {req_ready, op_valid, done}, 3'b100);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    run_xfer(32'h0000_0100, 24'd32, 1'b0, 1'b0, "R3", 1'b0); // aligned body only
    run_xfer(32'h0000_0013, 24'd30, 1'b0, 1'b0, "R2", 1'b0); // head 5, body 24, tail 1
    run_xfer(32'h0000_0040, 24'd7,  1'b0, 1'b0, "R4", 1'b1); // tail only
    run_xfer(32'h0000_0200, 24'd0,  1'b0, 1'b0, "R5", 1'b1); // zero count
    run_xfer(32'h0000_0021, 24'd3,  1'b0, 1'b0, "R6", 1'b1); // ends inside head
    run_xfer(32'h0000_0006, 24'd20, 1'b1, 1'b0, "R7", 1'b0); // stalls across phases
    run_xfer(32'h0000_0305, 24'd19, 1'b0, 1'b1, "R8", 1'b0); // request while busy
    run_xfer(32'h0000_0007, 24'd9,  1'b1, 1'b0, "R10", 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule